// File: doc/BRIEF.md
# Processor Trace Nibble Output Port

This block turns per-cycle execution events from a processor core into a narrow trace stream for an external debug probe. Two 4-bit outputs are driven every clock. The status nibble carries a code for what the core did in the previous cycle. The data nibble carries captured values: operands written on purpose for the probe, and branch target addresses. These values are serialized four bits at a time, least significant nibble first.

Captures wait in a two-entry, 32-bit holding buffer. A transfer starts with a size marker on the status nibble, in the same cycle as the first data nibble. The marker can only take a cycle in which the status port would otherwise show plain continued execution, so instruction codes are never lost. When both buffer entries are occupied, the block raises a stall to the core. While the stall is high, the core's events are not taken.

Top module: `trace_port`

## Requirements
- R1: While reset is high and in the first cycle after it, the status nibble is 0x0, the data nibble is 0x0 and the stall is low, with the buffer empty.
- R2: An event taken in cycle t sets the status nibble in cycle t+1 to one of these codes: continue=0x0 (event kind 0), begin instruction=0x1 (kind 1), user-mode entry=0x3 (kind 2), pulse=0x4 (kind 3), write-debug=0x4 (kind 4), taken branch=0x5 (kind 5). The codes 0x2 and 0x6 never appear.
- R3: A write-debug event (kind 4) captures its operand with a byte count taken from the size input: 0 gives 1 byte, 1 gives 2 bytes, 2 or 3 give 4 bytes.
- R4: A taken-branch event (kind 5) captures its target address with the byte count taken from the branch-bytes setting, 1 to 4. Settings above 4 mean 4. A setting of 0 captures nothing, and only 0x5 is shown.
- R5: A transfer of N bytes shows the marker 0x8+N-1 on the status nibble in the same cycle as its first data nibble. It then sends 2N nibbles, one per cycle, least significant first.
- R6: A transfer begins only in a cycle whose status would otherwise be 0x0. Its earliest start is two cycles after the capturing event.
- R7: The data nibble is 0x0 whenever no transfer is in progress. At least one cycle with the data nibble at 0x0 separates two transfers.
- R8: The stall is high exactly while both buffer entries are occupied. It drops in the cycle after the last nibble of the oldest entry is shown.
- R9: An event presented while the stall is high is ignored. The next status is 0x0 or a marker, and nothing is captured.
- R10: Event kinds 6 and 7 act as continue: status 0x0 and no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_kind_i | input | 3 | Event kind for this cycle (0 continue, 1 begin, 2 user entry, 3 pulse, 4 write-debug, 5 taken branch) |
| ev_size_i | input | 2 | Write-debug operand size (0 byte, 1 word, 2/3 long) |
| ev_data_i | input | 32 | Operand or branch target to capture |
| br_bytes_i | input | 3 | Number of branch target bytes to capture (0 disables) |
| stall_o | output | 1 | Core stall, high while the buffer is full |
| pst_o | output | 4 | Status nibble |
| dd_o | output | 4 | Data nibble |

## Verification
The assertions assume that the core honours the stall: it presents no event it expects to be taken while stall_o is high. They also assume the kind, size and branch-bytes inputs are defined values in every cycle after reset. The stimulus draws every input from $urandom each cycle, including events during stall cycles and the unused kinds 6 and 7. The bench's cycle model treats events during a stall as dropped, matching R9, so any overflow of the buffer would show up as a mismatch on the ports.

// File: rtl/trace_pkg.sv
package trace_pkg;

    localparam int DATA_W    = 32;
    localparam int NIB_W     = 4;
    localparam int NIBS      = DATA_W / NIB_W;
    localparam int MAX_BYTES = DATA_W / 8;
    localparam int NB_W      = $clog2(MAX_BYTES + 1);
    localparam int IDX_W     = $clog2(NIBS);

    typedef enum logic [2:0] {
        EV_NONE   = 3'd0,
        EV_BEGIN  = 3'd1,
        EV_USER   = 3'd2,
        EV_PULSE  = 3'd3,
        EV_WDATA  = 3'd4,
        EV_BRANCH = 3'd5
    } ev_kind_e;

    typedef enum logic [NIB_W-1:0] {
        ST_CONT   = 4'h0,
        ST_BEGIN  = 4'h1,
        ST_USER   = 4'h3,
        ST_PW     = 4'h4,
        ST_BRANCH = 4'h5,
        ST_MARK1  = 4'h8
    } status_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [NB_W-1:0]   nbytes;
    } cap_t;

    function automatic logic [NB_W-1:0] wdata_bytes(input logic [1:0] size);
        case (size)
            2'd0:    return NB_W'(1);
            2'd1:    return NB_W'(2);
            default: return NB_W'(MAX_BYTES);
        endcase
    endfunction

    function automatic logic [NB_W-1:0] branch_bytes(input logic [2:0] cfg);
        if (int'(cfg) > MAX_BYTES) return NB_W'(MAX_BYTES);
        return NB_W'(cfg);
    endfunction

    function automatic logic [NIB_W-1:0] marker_of(input logic [NB_W-1:0] nb);
        return NIB_W'(ST_MARK1) + NIB_W'(nb) - NIB_W'(1);
    endfunction

    function automatic logic [NIB_W-1:0] nibble_at(input logic [DATA_W-1:0] d,
                                                    input logic [IDX_W-1:0] idx);
        return d[idx*NIB_W +: NIB_W];
    endfunction

endpackage

// File: rtl/trace_status_sel.sv
module trace_status_sel
    import trace_pkg::*;
(
    input  logic [2:0]        ev_kind_i,
    input  logic [1:0]        ev_size_i,
    input  logic [DATA_W-1:0] ev_data_i,
    input  logic [2:0]        br_bytes_i,
    input  logic              stall_i,
    output logic [NIB_W-1:0]  code_o,
    output logic              push_o,
    output cap_t              entry_o
);

    logic [NB_W-1:0] nb;

    always_comb begin
        code_o = ST_CONT;
        push_o = 1'b0;
        nb     = '0;
        if (!stall_i) begin
            case (ev_kind_i)
                EV_BEGIN:  code_o = ST_BEGIN;
                EV_USER:   code_o = ST_USER;
                EV_PULSE:  code_o = ST_PW;
                EV_WDATA: begin
                    code_o = ST_PW;
                    nb     = wdata_bytes(ev_size_i);
                    push_o = 1'b1;
                end
                EV_BRANCH: begin
                    code_o = ST_BRANCH;
                    nb     = branch_bytes(br_bytes_i);
                    push_o = (nb != '0);
                end
                default:   code_o = ST_CONT;
            endcase
        end
        entry_o.data   = ev_data_i;
        entry_o.nbytes = nb;
    end

endmodule

// File: rtl/trace_fifo.sv
module trace_fifo
    import trace_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic push_i,
    input  cap_t entry_i,
    input  logic pop_i,
    output cap_t head_o,
    output logic nonempty_o,
    output logic full_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    cap_t             mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        if (int'(p) == DEPTH - 1) return '0;
        return p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_i) wr_ptr <= ptr_inc(wr_ptr);
            if (pop_i)  rd_ptr <= ptr_inc(rd_ptr);
            case ({push_i, pop_i})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (push_i && int'(wr_ptr) == g) begin
                mem[g] <= entry_i;
            end
        end
    end

    assign head_o     = mem[rd_ptr];
    assign nonempty_o = (cnt != '0);
    assign full_o     = (int'(cnt) == DEPTH);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt) == DEPTH) |-> !push_i || pop_i); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> cnt != '0); // R8

endmodule

// File: rtl/trace_serializer.sv
module trace_serializer
    import trace_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] code_i,
    input  cap_t             head_i,
    input  logic             nonempty_i,
    output logic             pop_o,
    output logic [NIB_W-1:0] pst_o,
    output logic [NIB_W-1:0] dd_o
);

    logic             active;
    logic [IDX_W-1:0] idx;
    logic [IDX_W:0]   last_wide;
    logic [IDX_W-1:0] last;
    logic             start;

    assign last_wide = {head_i.nbytes, 1'b0} - (IDX_W + 1)'(1);
    assign last      = last_wide[IDX_W-1:0];
    assign start     = !active && nonempty_i && (code_i == ST_CONT);
    assign pop_o     = active && (idx == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            pst_o  <= ST_CONT;
            dd_o   <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
            pst_o  <= marker_of(head_i.nbytes);
            dd_o   <= nibble_at(head_i.data, '0);
        end else if (active && !pop_o) begin
            idx    <= idx + IDX_W'(1);
            pst_o  <= code_i;
            dd_o   <= nibble_at(head_i.data, idx + IDX_W'(1));
        end else begin
            active <= 1'b0;
            pst_o  <= code_i;
            dd_o   <= '0;
        end
    end

    AST_MARKER_ON_START: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> pst_o[3]); // R5
    AST_START_ON_CONT: assert property (@(posedge clk) disable iff (rst)
        (!active && nonempty_i && code_i != ST_CONT) |=> !pst_o[3]); // R6
    AST_GAP_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        pop_o |=> !active && dd_o == '0); // R7

endmodule

// File: rtl/trace_port.sv
module trace_port
    import trace_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        ev_kind_i,
    input  logic [1:0]        ev_size_i,
    input  logic [DATA_W-1:0] ev_data_i,
    input  logic [2:0]        br_bytes_i,
    output logic              stall_o,
    output logic [NIB_W-1:0]  pst_o,
    output logic [NIB_W-1:0]  dd_o
);

    logic             push;
    logic             pop;
    logic             nonempty;
    logic             full;
    logic [NIB_W-1:0] code;
    cap_t             entry;
    cap_t             head;

    trace_status_sel u_sel (
        .ev_kind_i  (ev_kind_i),
        .ev_size_i  (ev_size_i),
        .ev_data_i  (ev_data_i),
        .br_bytes_i (br_bytes_i),
        .stall_i    (full),
        .code_o     (code),
        .push_o     (push),
        .entry_o    (entry)
    );

    trace_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push_i     (push),
        .entry_i    (entry),
        .pop_i      (pop),
        .head_o     (head),
        .nonempty_o (nonempty),
        .full_o     (full)
    );

    trace_serializer u_ser (
        .clk        (clk),
        .rst        (rst),
        .code_i     (code),
        .head_i     (head),
        .nonempty_i (nonempty),
        .pop_o      (pop),
        .pst_o      (pst_o),
        .dd_o       (dd_o)
    );

    assign stall_o = full;

    AST_NO_RESERVED: assert property (@(posedge clk) disable iff (rst)
        pst_o != 4'h2 && pst_o != 4'h6); // R2
    AST_STALL_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(stall_o) |-> $past(push)); // R8
    AST_STALL_IGNORE: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> (pst_o == ST_CONT) || pst_o[3]); // R9

endmodule

// File: tb/sim_trace_port.sv
module sim_trace_port;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  ev_kind  = '0;
    logic [1:0]  ev_size  = '0;
    logic [31:0] ev_data  = '0;
    logic [2:0]  br_bytes = '0;
    logic        stall;
    logic [3:0]  pst;
    logic [3:0]  dd;

    int checks = 0;
    int errors = 0;

    logic [31:0] mdat [2];
    int          mnb  [2];
    int          mcnt, midx;
    bit          mact;
    logic [3:0]  mpst, mdd;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_port u0 (
        .clk(clk), .rst(rst), .ev_kind_i(ev_kind), .ev_size_i(ev_size),
        .ev_data_i(ev_data), .br_bytes_i(br_bytes),
        .stall_o(stall), .pst_o(pst), .dd_o(dd)
    );

    function automatic logic [3:0] exp_code(input logic [2:0] k);
        case (k)
            3'd1: return 4'h1;
            3'd2: return 4'h3;
            3'd3, 3'd4: return 4'h4;
            3'd5: return 4'h5;
            default: return 4'h0;
        endcase
    endfunction

    function automatic int exp_wbytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic int exp_bbytes(input logic [2:0] c);
        return (c > 3'd4) ? 4 : int'(c);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ev_kind = '0;
        repeat (2) @(negedge clk);
        chk(pst == 4'h0, "R1", "pst in reset", pst, 0);
        chk(dd == 4'h0, "R1", "dd in reset", dd, 0);
        chk(stall == 1'b0, "R1", "stall in reset", stall, 0);
        rst = 1'b0;
        mcnt = 0; mact = 0; midx = 0; mpst = 0; mdd = 0;
    endtask

    task automatic step(input logic [2:0] k, input logic [1:0] s,
                        input logic [31:0] d, input logic [2:0] c, input string tag);
        bit stl, acc, cap;
        int nb;
        logic [3:0] code;
        @(negedge clk);
        ev_kind = k; ev_size = s; ev_data = d; br_bytes = c;
        stl  = (mcnt == 2);
        acc  = !stl && (k >= 3'd1) && (k <= 3'd5);
        code = acc ? exp_code(k) : 4'h0;
        cap  = acc && (k == 3'd4 || (k == 3'd5 && c != 3'd0));
        nb   = (k == 3'd4) ? exp_wbytes(s) : exp_bbytes(c);
        if (!mact && mcnt != 0 && code == 4'h0) begin
            mact = 1; midx = 0;
            mpst = 4'(8 + mnb[0] - 1);
            mdd  = mdat[0][3:0];
        end else if (mact && midx != 2*mnb[0]-1) begin
            midx++;
            mpst = code;
            mdd  = 4'((mdat[0] >> (4*midx)) & 32'hF);
        end else if (mact) begin
            mact = 0;
            mdat[0] = mdat[1]; mnb[0] = mnb[1];
            mcnt--;
            mpst = code; mdd = 0;
        end else begin
            mpst = code; mdd = 0;
        end
        if (cap) begin
            mdat[mcnt] = d; mnb[mcnt] = nb; mcnt++;
        end
        @(posedge clk); #1;
        chk(pst == mpst, tag, "pst", pst, mpst);
        chk(dd == mdd, "R5", "dd", dd, mdd);
        chk(stall == (mcnt == 2), "R8", "stall", stall, (mcnt == 2));
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(3'd0, 2'd0, 32'h0, 3'd0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        step(3'd0, 0, 0, 0, "R1");
        chk(pst == 4'h0 && dd == 4'h0 && !stall, "R1", "after reset", pst, 0);

        step(3'd1, 0, 0, 0, "R2"); chk(pst == 4'h1, "R2", "begin code", pst, 1);
        step(3'd2, 0, 0, 0, "R2"); chk(pst == 4'h3, "R2", "user code", pst, 3);
        step(3'd3, 0, 0, 0, "R2"); chk(pst == 4'h4, "R2", "pulse code", pst, 4);
        step(3'd6, 0, 32'hFFFF, 4, "R10"); chk(pst == 4'h0, "R10", "kind6", pst, 0);
        step(3'd7, 0, 32'hFFFF, 4, "R10"); chk(pst == 4'h0 && dd == 0, "R10", "kind7", pst, 0);
        idle(2, "R10");

        // R3 byte write: 4, then marker 8 with nibbles 5, A
        step(3'd4, 2'd0, 32'hDEADBEA5, 0, "R3"); chk(pst == 4'h4, "R3", "wdata code", pst, 4);
        step(3'd0, 0, 0, 0, "R5"); chk(pst == 4'h8 && dd == 4'h5, "R5", "byte marker+lsn", {pst, dd}, 8'h85);
        step(3'd0, 0, 0, 0, "R5"); chk(pst == 4'h0 && dd == 4'hA, "R5", "second nibble", {pst, dd}, 8'h0A);
        step(3'd0, 0, 0, 0, "R7"); chk(dd == 4'h0, "R7", "idle dd", dd, 0);

        // R4 branch with zero bytes: no capture
        step(3'd5, 0, 32'h12345678, 3'd0, "R4"); chk(pst == 4'h5, "R4", "branch code", pst, 5);
        idle(3, "R4"); chk(dd == 4'h0 && pst == 4'h0, "R4", "no transfer", dd, 0);

        // R4 branch with 3 bytes: marker 0xA, nibbles 8,7,6,5,4,3
        step(3'd5, 0, 32'h12345678, 3'd3, "R4");
        step(3'd0, 0, 0, 0, "R4"); chk(pst == 4'hA && dd == 4'h8, "R4", "3-byte marker", {pst, dd}, 8'hA8);
        idle(7, "R4");

        // R6 marker deferred while instructions keep the status busy
        step(3'd4, 2'd1, 32'h0000BEEF, 0, "R6");
        step(3'd1, 0, 0, 0, "R6");
        step(3'd1, 0, 0, 0, "R6"); chk(pst == 4'h1 && dd == 0, "R6", "deferred", {pst, dd}, 8'h10);
        step(3'd0, 0, 0, 0, "R6"); chk(pst == 4'h9 && dd == 4'hF, "R6", "late marker", {pst, dd}, 8'h9F);
        idle(6, "R6");

        // R8/R9 fill the buffer with three long writes back to back
        step(3'd4, 2'd2, 32'h11111111, 0, "R8");
        step(3'd4, 2'd3, 32'h22222222, 0, "R8"); chk(stall == 1'b1, "R8", "stall full", stall, 1);
        step(3'd4, 2'd2, 32'h33333333, 0, "R9"); chk(pst == 4'hB, "R9", "stalled event dropped", pst, 4'hB);
        idle(20, "R9");
        chk(stall == 1'b0 && dd == 4'h0, "R9", "drained", stall, 0);

        do_reset();
        step(3'd0, 0, 0, 0, "R1");

        for (int i = 0; i < 6000; i++) begin
            int r;
            logic [2:0] k;
            r = $urandom % 16;
            if (r < 6) k = 3'd0;
            else if (r < 9) k = 3'd1;
            else if (r == 9) k = 3'd2;
            else if (r == 10) k = 3'd3;
            else if (r < 13) k = 3'd4;
            else if (r < 15) k = 3'd5;
            else k = 3'(6 + ($urandom % 2));
            step(k, 2'($urandom), $urandom, 3'($urandom), "R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end

endmodule